// File: doc/BRIEF.md
# Chained Serial-to-Parallel Register With Held Output

This block turns a serial bit stream into a wide parallel word in two steps. Each unit holds an 8-bit shift chain and an 8-bit holding bank. The shift chain and the holding bank each have their own rising-edge clock and their own asynchronous active-low clear. Bits walk through the shift chain one stage per shift-clock pulse. A pulse on the hold clock copies the whole chain into the holding bank in one step, and the parallel outputs show only that bank.

A parameter sets how many 8-bit units are chained. The last stage of each unit feeds the first stage of the next. The last stage of the final unit is brought out as a cascade bit, so further blocks can be hung off the end. A controller can shift a full frame in while the outputs still show the previous frame, and then update every output at the same moment. The two clock inputs may be driven from one net. In that case the held word trails the chain by one pulse.

Top module: `sls_chain_top`

## Requirements
- R1: On each rising edge of `shiftClk` with `shiftClrN` high, stage 0 loads `serIn` and every other stage takes the value its predecessor had before the edge.
- R2: A falling edge of `shiftClk` leaves every shift stage and `cascadeOut` unchanged.
- R3: Driving `shiftClrN` low sets every shift stage to 0 at once, without a clock edge. The holding bank keeps its value.
- R4: Driving `storeClrN` low sets the holding bank, and so `parOut`, to 0 at once, without a clock edge. The shift stages and `cascadeOut` are not affected.
- R5: On a rising edge of `storeClk` with `storeClrN` high, the holding bank takes all shift stages as they were just before the edge. A falling edge of `storeClk` changes nothing.
- R6: `cascadeOut` always equals the last shift stage of the final unit. It changes on `shiftClk`, not on `storeClk`.
- R7: When `shiftClk` and `storeClk` rise together, the holding bank takes the shift contents from before that edge, so it trails the chain by exactly one pulse.
- R8: `parOut` changes only on a `storeClk` edge or a `storeClrN` clear. Shifting alone never disturbs it.
- R9: While a clear input is held low, clock edges on the register it clears have no effect, and that register stays 0.
- R10: `parOut` is 8*UNITS bits wide. Bit 8k+i holds stage i of unit k. Stage 0 of unit 0 takes `serIn`, stage 0 of unit k+1 takes stage 7 of unit k, and `cascadeOut` is stage 7 of the last unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| shiftClk | input | 1 | Shift clock, rising edge active |
| shiftClrN | input | 1 | Asynchronous clear of all shift stages, active low |
| serIn | input | 1 | Serial data into stage 0 of unit 0 |
| storeClk | input | 1 | Holding-bank clock, rising edge active |
| storeClrN | input | 1 | Asynchronous clear of the holding bank, active low |
| parOut | output | 8*UNITS | Holding-bank contents |
| cascadeOut | output | 1 | Last shift stage of the final unit |

## Verification
Two functions can fall in the same instant: a shift edge and a hold edge. When both clocks come from one net, the hold capture must see the chain from before the shift. The bench provokes this by raising both clocks in one statement over a run of pulses. It judges each pulse against a model that snapshots the chain before advancing it, so the expected held word is always one pulse behind. The bench also holds each clear low while its register's clock is pulsed, and checks that the clear wins.

// File: rtl/sls_pkg.sv
package sls_pkg;
  // width of one chained unit
  localparam int unsigned UNIT_W = 8;
endpackage

// File: rtl/sls_shift_unit.sv
module sls_shift_unit #(
  parameter int unsigned W = sls_pkg::UNIT_W
) (
  input  logic         shiftClk,
  input  logic         shiftClrN,
  input  logic         sin,
  output logic [W-1:0] stg,
  output logic         sout
);
  logic [W-1:0] stgQ;
  logic         armedQ;

  always_ff @(posedge shiftClk or negedge shiftClrN) begin
    if (!shiftClrN) stgQ <= '0;
    else            stgQ <= {stgQ[W-2:0], sin};
  end

  // high only when an edge has passed with no clear since it
  always_ff @(posedge shiftClk or negedge shiftClrN) begin
    if (!shiftClrN) armedQ <= 1'b0;
    else            armedQ <= 1'b1;
  end

  assign stg  = stgQ;
  assign sout = stgQ[W-1];

  p_first_stage_r1: assert property (@(posedge shiftClk) disable iff (!shiftClrN)
    armedQ |-> stgQ[0] == $past(sin));

  p_stage_walk_r1: assert property (@(posedge shiftClk) disable iff (!shiftClrN)
    armedQ |-> stgQ[W-1:1] == $past(stgQ[W-2:0]));

  p_clear_hold_r9: assert property (@(posedge shiftClk)
    (!shiftClrN && !armedQ) |-> stgQ == '0);
endmodule

// File: rtl/sls_store_bank.sv
module sls_store_bank #(
  parameter int unsigned N = 16
) (
  input  logic         storeClk,
  input  logic         storeClrN,
  input  logic [N-1:0] shiftWord,
  output logic [N-1:0] held
);
  logic [N-1:0] heldQ;
  logic         armedQ;

  always_ff @(posedge storeClk or negedge storeClrN) begin
    if (!storeClrN) heldQ <= '0;
    else            heldQ <= shiftWord;
  end

  always_ff @(posedge storeClk or negedge storeClrN) begin
    if (!storeClrN) armedQ <= 1'b0;
    else            armedQ <= 1'b1;
  end

  assign held = heldQ;

  p_capture_r5: assert property (@(posedge storeClk) disable iff (!storeClrN)
    armedQ |-> heldQ == $past(shiftWord));

  p_store_clear_r4: assert property (@(posedge storeClk)
    (!storeClrN && !armedQ) |-> heldQ == '0);
endmodule

// File: rtl/sls_chain_top.sv
module sls_chain_top #(
  parameter int unsigned UNITS = 2
) (
  input  logic                           shiftClk,
  input  logic                           shiftClrN,
  input  logic                           serIn,
  input  logic                           storeClk,
  input  logic                           storeClrN,
  output logic [sls_pkg::UNIT_W*UNITS-1:0] parOut,
  output logic                           cascadeOut
);
  localparam int unsigned UW = sls_pkg::UNIT_W;
  localparam int unsigned NW = UW * UNITS;

  logic [UNITS:0]  link;
  logic [NW-1:0]   shiftWord;

  assign link[0] = serIn;

  for (genvar k = 0; k < UNITS; k++) begin : g_unit
    sls_shift_unit #(.W(UW)) unit_i (
      .shiftClk (shiftClk),
      .shiftClrN(shiftClrN),
      .sin      (link[k]),
      .stg      (shiftWord[UW*k +: UW]),
      .sout     (link[k+1])
    );
  end

  sls_store_bank #(.N(NW)) bank_i (
    .storeClk (storeClk),
    .storeClrN(storeClrN),
    .shiftWord(shiftWord),
    .held     (parOut)
  );

  assign cascadeOut = link[UNITS];
endmodule

// File: tb/sls_chain_top_tb_top.sv
module sls_chain_top_tb_top;
  localparam int unsigned UNITS = 2;
  localparam int unsigned NW = 8 * UNITS;

  logic clk = 1'b0;
  logic shiftClk = 1'b0, shiftClrN = 1'b0, serIn = 1'b0;
  logic storeClk = 1'b0, storeClrN = 1'b0;
  logic [NW-1:0] parOut;
  logic cascadeOut;

  logic [NW-1:0] shiftM, storeM;
  int checks = 0, errors = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;

  sls_chain_top #(.UNITS(UNITS)) dut_i (
    .shiftClk(shiftClk), .shiftClrN(shiftClrN), .serIn(serIn),
    .storeClk(storeClk), .storeClrN(storeClrN),
    .parOut(parOut), .cascadeOut(cascadeOut)
  );

  task automatic check(input string tag);
    checks++;
    if (parOut !== storeM) begin
      errors++;
      $display("FAIL %s parOut actual=%h expected=%h", tag, parOut, storeM);
    end
    checks++;
    if (cascadeOut !== shiftM[NW-1]) begin
      errors++;
      $display("FAIL %s cascadeOut actual=%b expected=%b", tag, cascadeOut, shiftM[NW-1]);
    end
  endtask

  function automatic logic nextBit();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  task automatic shiftPulse(input logic b, input string tag);
    @(negedge clk);
    serIn = b;
    #2 shiftClk = 1'b1;
    if (shiftClrN) shiftM = {shiftM[NW-2:0], b};
    #2 check(tag);
    #2 shiftClk = 1'b0;
    #2 check(tag);
  endtask

  task automatic storePulse(input string tag);
    @(negedge clk);
    #2 storeClk = 1'b1;
    if (storeClrN) storeM = shiftM;
    #2 check(tag);
    #2 storeClk = 1'b0;
    #2 check(tag);
  endtask

  task automatic tiedPulse(input logic b, input string tag);
    @(negedge clk);
    serIn = b;
    #2;
    storeM = shiftM;
    shiftM = {shiftM[NW-2:0], b};
    shiftClk = 1'b1; storeClk = 1'b1;
    #2 check(tag);
    #2 begin shiftClk = 1'b0; storeClk = 1'b0; end
    #2 check(tag);
  endtask

  task automatic testReset();
    shiftM = '0; storeM = '0;
    #5 check("R3_R4_reset");
    @(negedge clk);
    shiftClrN = 1'b1; storeClrN = 1'b1;
    #2 check("R3_R4_release");
  endtask

  // R1 R8 R10: stream bits, held word must not move until a store edge
  task automatic testStream();
    for (int i = 0; i < 3 * NW / 2; i++) shiftPulse(nextBit(), "R1_R8_R10_stream");
    storePulse("R5_R10_capture");
    shiftPulse(1'b1, "R1_R2_R6_one");
    shiftPulse(1'b0, "R1_R2_R6_zero");
    for (int i = 0; i < NW; i++) shiftPulse((i % 3) == 0, "R10_walk");
    storePulse("R5_capture_walk");
  endtask

  // R3: shift clear mid-run, held word untouched until store
  task automatic testShiftClear();
    for (int i = 0; i < 5; i++) shiftPulse(1'b1, "R1_fill");
    @(negedge clk);
    shiftClrN = 1'b0; shiftM = '0;
    #2 check("R3_async_clear");
    shiftClrN = 1'b1;
    #2 check("R3_release");
    storePulse("R3_R5_store_zero");
  endtask

  // R4 R6: store clear leaves the chain alone
  task automatic testStoreClear();
    for (int i = 0; i < NW; i++) shiftPulse(1'b1, "R1_fill_ones");
    storePulse("R5_ones");
    @(negedge clk);
    storeClrN = 1'b0; storeM = '0;
    #2 check("R4_R6_store_clear");
    storeClrN = 1'b1;
    #2 check("R4_release");
    storePulse("R4_shift_kept");
  endtask

  // R9: clocks while clears are held low
  task automatic testHeldClear();
    @(negedge clk);
    shiftClrN = 1'b0; storeClrN = 1'b0; shiftM = '0; storeM = '0;
    #2 check("R9_enter");
    shiftPulse(1'b1, "R9_shift_blocked");
    storePulse("R9_store_blocked");
    @(negedge clk);
    shiftClrN = 1'b1; storeClrN = 1'b1;
    #2 check("R9_release");
    storePulse("R9_still_empty");
  endtask

  // R7: one net drives both clocks
  task automatic testTied();
    for (int i = 0; i < NW + 4; i++) tiedPulse(nextBit(), "R7_tied_lag");
  endtask

  initial begin
    testReset();
    testStream();
    testShiftClear();
    testStoreClear();
    testHeldClear();
    testTied();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule